// File: doc/BRIEF.md
# Power-Management Event and Timer Register Block

This block is an I/O-decoded register file for system power management. A 64-byte window, placed at a programmable base address, holds a 16-bit event status word, a matching 16-bit event enable word, a 16-bit control word, a free-running timer, a general-purpose event area and a 32-bit system-management enable word. A single level output, the system control interrupt (SCI), is high while any of four selected event sources has both its status and its enable bit set.

Accesses are one, two or four bytes wide. Only certain offsets decode natively at a given width. An access of another width is broken into narrower pieces aimed at the same offset. A write sends its pieces lowest part first. A read places the first piece in the upper half and the second in the lower half. All pieces of one bus access take effect in the same clock edge. Status bits of the event word and of the general-purpose area are cleared by writing ones. The power-button, real-time-clock and general-purpose event inputs set them.

Top module: `pwrmgmt_regfile`

## Requirements
- R1: `sci` is high exactly when (status AND enable) has a one in bit 0 (timer), bit 5 (global lock), bit 8 (power button) or bit 10 (RTC). A pair at any other bit position never raises it.
- R2: `sci` follows the registers with no extra stage. A write to the status or enable word at one clock edge is reflected on `sci` straight after that same edge.
- R3: The status word sits at offset 0x00. Writing a one clears a bit, and writing a zero leaves it. An event input that fires in the same cycle as a clear of its bit wins, and the bit stays set.
- R4: The timer counts up by one each clock from zero after reset, with TMR_BITS bits. A 4-byte read at offset 0x08 returns it zero-extended. Its status bit (bit 0) is set when the timer's top bit changes, but only if enable bit 0 is one and status bit 0 is zero in that cycle.
- R5: Two-byte registers: status at 0x00, enable at 0x02, control at 0x04 (read/write). Four-byte registers: the timer at 0x08 (read only) and system-management enable at 0x30 (read/write). A byte read anywhere outside the general-purpose area returns zero.
- R6: The general-purpose area is read and written one byte at a time. Bytes 0x20..0x27 are status bits, which `gpe_evt` bit 8*i+j sets in byte i and a written one clears. Bytes 0x28..0x2F are plain enable bytes.
- R7: A 2-byte access to an offset that is not 0x00, 0x02 or 0x04 becomes two byte accesses at that same offset. The write sends bits 7:0 first and then bits 15:8, and the read returns {b,b}.
- R8: A 4-byte access to an offset other than 0x08 or 0x30 becomes two 2-byte accesses at that same offset. The write sends bits 15:0 first and then bits 31:16, and the read returns {w,w}. A 4-byte write to 0x08 changes nothing.
- R9: The base is taken from `io_base` one clock late. A base of zero, or one whose low 6 bits are not zero, decodes nothing: reads return zero and writes are dropped.
- R10: Reset clears the status, enable, control, timer, general-purpose and system-management state, unmaps the window, and leaves `sci` low.
- R11: A pulse on `pwrbtn_evt` sets status bit 8. With enable bit 8 set, `sci` then rises after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_base | input | ADDR_W | Window base address (0 = unmapped) |
| io_addr | input | ADDR_W | Access address |
| io_size | input | 2 | 0 = byte, 1 = 2 bytes, 2 = 4 bytes, 3 = no access |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 32 | Write data, least-significant byte first |
| io_rdata | output | 32 | Read data, valid in the strobe cycle, zero otherwise |
| pwrbtn_evt | input | 1 | Power-button / power-down request pulse |
| rtc_evt | input | 1 | Real-time-clock event pulse |
| gpe_evt | input | 8*GPE_HALF | General-purpose event set pulses |
| sci | output | 1 | System control interrupt level |

## Verification
Read data is combinational from the registers and the current strobe, so it is due in the same cycle as `io_rd`. A write, an event pulse or a timer step shows up after the very next rising edge, both on a following read and on `sci`. A base change takes one extra edge before it decodes. The bench drives inputs on the falling edge. Shortly afterwards it compares `sci` and `io_rdata` against a behavioural model, and it advances the model only at the rising edge, so every comparison sees the state produced by exactly the preceding edges.

// File: rtl/pmr_pkg.sv
package pmr_pkg;

    // Window offset width: 64-byte window
    localparam int OFF_W = 6;

    localparam logic [OFF_W-1:0] OFS_STS = 6'h00;
    localparam logic [OFF_W-1:0] OFS_EN  = 6'h02;
    localparam logic [OFF_W-1:0] OFS_CNT = 6'h04;
    localparam logic [OFF_W-1:0] OFS_TMR = 6'h08;
    localparam logic [OFF_W-1:0] OFS_GPE = 6'h20;
    localparam logic [OFF_W-1:0] OFS_SMI = 6'h30;

    // Event bit positions shared by status and enable words
    localparam int STB_TMR = 0;
    localparam int STB_GBL = 5;
    localparam int STB_PWR = 8;
    localparam int STB_RTC = 10;
    localparam logic [15:0] SCI_MASK = (16'h1 << STB_TMR) | (16'h1 << STB_GBL)
                                     | (16'h1 << STB_PWR) | (16'h1 << STB_RTC);

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_NONE  = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        WT_NONE = 2'd0,
        WT_STS  = 2'd1,
        WT_EN   = 2'd2,
        WT_CNT  = 2'd3
    } word_tgt_e;

    // All pieces of one access folded into a single-edge update:
    // *_or feeds write-one-to-clear fields, *_last feeds plain fields.
    typedef struct packed {
        logic        word_go;
        word_tgt_e   word_tgt;
        logic [15:0] word_or;
        logic [15:0] word_last;
        logic        byte_go;
        logic [7:0]  byte_or;
        logic [7:0]  byte_last;
        logic        smi_go;
        logic [31:0] smi_val;
    } wr_plan_t;

    function automatic word_tgt_e word_target(input logic [OFF_W-1:0] off);
        case (off)
            OFS_STS: return WT_STS;
            OFS_EN:  return WT_EN;
            OFS_CNT: return WT_CNT;
            default: return WT_NONE;
        endcase
    endfunction

    function automatic wr_plan_t plan_write(input acc_size_e sz,
                                            input logic [OFF_W-1:0] off,
                                            input logic [31:0] d);
        wr_plan_t p;
        p = '0;
        p.word_tgt = word_target(off);
        case (sz)
            SZ_BYTE: begin
                p.byte_go   = 1'b1;
                p.byte_or   = d[7:0];
                p.byte_last = d[7:0];
            end
            SZ_WORD: begin
                p.word_go   = 1'b1;
                p.word_or   = d[15:0];
                p.word_last = d[15:0];
            end
            SZ_DWORD: begin
                if (off == OFS_SMI) begin
                    p.smi_go  = 1'b1;
                    p.smi_val = d;
                end else begin
                    p.word_go   = 1'b1;
                    p.word_or   = d[15:0] | d[31:16];
                    p.word_last = d[31:16];
                end
            end
            default: ;
        endcase
        // a word piece with no word register falls to two byte pieces
        if (p.word_go && p.word_tgt == WT_NONE) begin
            p.word_go   = 1'b0;
            p.byte_go   = 1'b1;
            p.byte_or   = p.word_or[7:0] | p.word_or[15:8];
            p.byte_last = p.word_last[15:8];
        end
        return p;
    endfunction

endpackage

// File: rtl/pmr_decode.sv
module pmr_decode
    import pmr_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] io_base,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [1:0]        io_size,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [31:0]       io_wdata,
    output logic [OFF_W-1:0]  off,
    output logic              rd_hit,
    output acc_size_e         rd_size,
    output wr_plan_t          plan
);

    logic [ADDR_W-1:0] base_q;
    logic              mapped;
    logic              hit;
    acc_size_e         sz;

    always_ff @(posedge clk) begin
        if (rst) base_q <= '0;
        else     base_q <= io_base;
    end

    assign mapped  = (base_q != '0) && (base_q[OFF_W-1:0] == '0);
    assign hit     = mapped && (io_addr[ADDR_W-1:OFF_W] == base_q[ADDR_W-1:OFF_W]);
    assign off     = io_addr[OFF_W-1:0];
    assign sz      = acc_size_e'(io_size);
    assign rd_hit  = hit && io_rd;
    assign rd_size = sz;

    always_comb begin
        plan = plan_write(sz, off, io_wdata);
        if (!(hit && io_wr)) plan = '0;
    end

    // R9: a zero base seen on the previous edge never produces a read hit
    a_r9_base_zero_silent: assert property (@(posedge clk) disable iff (rst)
        (io_rd && $past(io_base) == '0) |-> !rd_hit);

endmodule

// File: rtl/pmr_pm1.sv
module pmr_pm1
    import pmr_pkg::*;
#(
    parameter int TMR_BITS = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  wr_plan_t            plan,
    input  logic                pwrbtn_evt,
    input  logic                rtc_evt,
    output logic [15:0]         sts,
    output logic [15:0]         en,
    output logic [15:0]         cnt,
    output logic [TMR_BITS-1:0] tmr,
    output logic                sci
);

    localparam int TMSB = TMR_BITS - 1;

    logic [TMR_BITS-1:0] tmr_nx;
    logic                msb_flip;
    logic                armed;
    logic [15:0]         set_vec;
    logic [15:0]         clr_vec;

    assign tmr_nx   = tmr + TMR_BITS'(1);
    assign msb_flip = tmr_nx[TMSB] ^ tmr[TMSB];
    assign armed    = en[STB_TMR] & ~sts[STB_TMR];

    always_comb begin
        set_vec          = '0;
        set_vec[STB_TMR] = msb_flip & armed;
        set_vec[STB_PWR] = pwrbtn_evt;
        set_vec[STB_RTC] = rtc_evt;
    end

    assign clr_vec = (plan.word_go && plan.word_tgt == WT_STS) ? plan.word_or : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            sts <= '0;
            en  <= '0;
            cnt <= '0;
            tmr <= '0;
        end else begin
            tmr <= tmr_nx;
            sts <= (sts & ~clr_vec) | set_vec;
            if (plan.word_go && plan.word_tgt == WT_EN)  en  <= plan.word_last;
            if (plan.word_go && plan.word_tgt == WT_CNT) cnt <= plan.word_last;
        end
    end

    assign sci = |(sts & en & SCI_MASK);

    // R4: timer status only appears when detection was armed
    a_r4_arm_only: assert property (@(posedge clk) disable iff (rst)
        $rose(sts[STB_TMR]) |-> $past(en[STB_TMR]));

    // R11: power-button pulse with its enable held raises sci
    a_r11_pwrbtn_sci: assert property (@(posedge clk) disable iff (rst)
        (pwrbtn_evt && en[STB_PWR] && !(plan.word_go && plan.word_tgt == WT_EN)) |=> sci);

    // R3: cleared bits without a competing set are zero afterwards
    a_r3_w1c: assert property (@(posedge clk) disable iff (rst)
        (clr_vec != '0) |=> ((sts & $past(clr_vec & ~set_vec)) == '0));

endmodule

// File: rtl/pmr_gpe.sv
module pmr_gpe
    import pmr_pkg::*;
#(
    parameter int HALF = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [OFF_W-1:0]     off,
    input  wr_plan_t             plan,
    input  logic [8*HALF-1:0]    gpe_evt,
    output logic [7:0]           rbyte
);

    localparam int NBYTES = 2 * HALF;

    logic [OFF_W-1:0]  idx;
    logic              in_blk;
    logic [8*HALF-1:0] st_flat;
    logic [8*HALF-1:0] en_flat;

    assign idx    = off - OFS_GPE;
    assign in_blk = (off >= OFS_GPE) && (idx < OFF_W'(NBYTES));

    for (genvar g = 0; g < HALF; g++) begin : g_byte
        logic [7:0] st_r;
        logic [7:0] en_r;
        logic       st_sel;
        logic       en_sel;

        assign st_sel = plan.byte_go && in_blk && (idx == OFF_W'(g));
        assign en_sel = plan.byte_go && in_blk && (idx == OFF_W'(g + HALF));

        always_ff @(posedge clk) begin
            if (rst) begin
                st_r <= '0;
                en_r <= '0;
            end else begin
                st_r <= (st_r & ~(st_sel ? plan.byte_or : 8'h00)) | gpe_evt[8*g +: 8];
                if (en_sel) en_r <= plan.byte_last;
            end
        end

        assign st_flat[8*g +: 8] = st_r;
        assign en_flat[8*g +: 8] = en_r;
    end

    always_comb begin
        rbyte = '0;
        for (int i = 0; i < HALF; i++) begin
            if (in_blk && idx == OFF_W'(i))        rbyte = st_flat[8*i +: 8];
            if (in_blk && idx == OFF_W'(i + HALF)) rbyte = en_flat[8*i +: 8];
        end
    end

endmodule

// File: rtl/pwrmgmt_regfile.sv
module pwrmgmt_regfile
    import pmr_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int TMR_BITS = 24,
    parameter int GPE_HALF = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ADDR_W-1:0]     io_base,
    input  logic [ADDR_W-1:0]     io_addr,
    input  logic [1:0]            io_size,
    input  logic                  io_wr,
    input  logic                  io_rd,
    input  logic [31:0]           io_wdata,
    output logic [31:0]           io_rdata,
    input  logic                  pwrbtn_evt,
    input  logic                  rtc_evt,
    input  logic [8*GPE_HALF-1:0] gpe_evt,
    output logic                  sci
);

    logic [OFF_W-1:0]    off;
    logic                rd_hit;
    acc_size_e           rd_size;
    wr_plan_t            plan;
    logic [15:0]         sts, en, cnt;
    logic [TMR_BITS-1:0] tmr;
    logic [7:0]          gbyte;
    logic [31:0]         smi_q;
    logic [15:0]         rw;
    logic [31:0]         rl;

    pmr_decode #(.ADDR_W(ADDR_W)) u_decode (
        .clk(clk), .rst(rst), .io_base(io_base), .io_addr(io_addr),
        .io_size(io_size), .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata),
        .off(off), .rd_hit(rd_hit), .rd_size(rd_size), .plan(plan)
    );

    pmr_pm1 #(.TMR_BITS(TMR_BITS)) u_pm1 (
        .clk(clk), .rst(rst), .plan(plan), .pwrbtn_evt(pwrbtn_evt),
        .rtc_evt(rtc_evt), .sts(sts), .en(en), .cnt(cnt), .tmr(tmr), .sci(sci)
    );

    pmr_gpe #(.HALF(GPE_HALF)) u_gpe (
        .clk(clk), .rst(rst), .off(off), .plan(plan),
        .gpe_evt(gpe_evt), .rbyte(gbyte)
    );

    always_ff @(posedge clk) begin
        if (rst)              smi_q <= '0;
        else if (plan.smi_go) smi_q <= plan.smi_val;
    end

    // read path: split reads repeat the same offset, first piece on top
    always_comb begin
        case (word_target(off))
            WT_STS:  rw = sts;
            WT_EN:   rw = en;
            WT_CNT:  rw = cnt;
            default: rw = {gbyte, gbyte};
        endcase
        if (off == OFS_TMR)      rl = 32'(tmr);
        else if (off == OFS_SMI) rl = smi_q;
        else                     rl = {rw, rw};
        io_rdata = '0;
        if (rd_hit) begin
            case (rd_size)
                SZ_BYTE:  io_rdata = {24'h0, gbyte};
                SZ_WORD:  io_rdata = {16'h0, rw};
                SZ_DWORD: io_rdata = rl;
                default:  io_rdata = '0;
            endcase
        end
    end

    // R10: first cycle out of reset has sci low
    a_r10_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !sci);

endmodule

// File: tb/test_pwrmgmt_regfile.sv
module test_pwrmgmt_regfile;

    localparam int CLK_PERIOD = 10;
    localparam int TB = 8;
    localparam int GH = 8;
    localparam int GW = 8 * GH;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [15:0]   io_base = '0;
    logic [15:0]   io_addr = '0;
    logic [1:0]    io_size = '0;
    logic          io_wr = 1'b0;
    logic          io_rd = 1'b0;
    logic [31:0]   io_wdata = '0;
    logic [31:0]   io_rdata;
    logic          pwrbtn_evt = 1'b0;
    logic          rtc_evt = 1'b0;
    logic [GW-1:0] gpe_evt = '0;
    logic          sci;

    int    n_checks = 0;
    int    n_errors = 0;
    string cur = "R10";
    bit [15:0] cur_base = 16'h0400;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwrmgmt_regfile #(.ADDR_W(16), .TMR_BITS(TB), .GPE_HALF(GH)) i_pwrmgmt_regfile (
        .clk(clk), .rst(rst), .io_base(io_base), .io_addr(io_addr),
        .io_size(io_size), .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .pwrbtn_evt(pwrbtn_evt), .rtc_evt(rtc_evt),
        .gpe_evt(gpe_evt), .sci(sci)
    );

    // ---------------- behavioural reference ----------------
    bit [15:0] m_base, m_sts, m_en, m_cnt;
    bit [31:0] m_tmr, m_smi;
    bit [7:0]  m_gs [GH];
    bit [7:0]  m_ge [GH];

    function automatic bit m_hit();
        return (m_base != 0) && (m_base[5:0] == 0) && (io_addr[15:6] == m_base[15:6]);
    endfunction

    function automatic bit [7:0] mrb(int off);
        if (off >= 32 && off < 32 + GH) return m_gs[off - 32];
        if (off >= 32 + GH && off < 32 + 2*GH) return m_ge[off - 32 - GH];
        return 8'h00;
    endfunction

    function automatic bit [15:0] mrw(int off);
        bit [15:0] v;
        case (off)
            0: return m_sts;
            2: return m_en;
            4: return m_cnt;
            default: begin
                v = 0;
                for (int i = 0; i < 2; i++) v = (v << 8) | 16'(mrb(off));
                return v;
            end
        endcase
    endfunction

    function automatic bit [31:0] mrl(int off);
        bit [31:0] v;
        case (off)
            8:  return m_tmr;
            48: return m_smi;
            default: begin
                v = 0;
                for (int i = 0; i < 2; i++) v = (v << 16) | 32'(mrw(off));
                return v;
            end
        endcase
    endfunction

    task automatic mwb(int off, bit [31:0] v);
        if (off >= 32 && off < 32 + GH) m_gs[off - 32] &= ~v[7:0];
        else if (off >= 32 + GH && off < 32 + 2*GH) m_ge[off - 32 - GH] = v[7:0];
    endtask

    task automatic mww(int off, bit [31:0] v);
        case (off)
            0: m_sts &= ~v[15:0];
            2: m_en = v[15:0];
            4: m_cnt = v[15:0];
            default: for (int i = 0; i < 2; i++) begin
                mwb(off, v & 32'hFF);
                v = v >> 8;
            end
        endcase
    endtask

    task automatic mwl(int off, bit [31:0] v);
        if (off == 48) m_smi = v;
        else for (int i = 0; i < 2; i++) begin
            mww(off, v & 32'hFFFF);
            v = v >> 16;
        end
    endtask

    task automatic model_update();
        bit armed;
        bit flip;
        bit [31:0] nt;
        int off;
        if (rst) begin
            m_base = 0; m_sts = 0; m_en = 0; m_cnt = 0; m_tmr = 0; m_smi = 0;
            foreach (m_gs[i]) m_gs[i] = 0;
            foreach (m_ge[i]) m_ge[i] = 0;
            return;
        end
        armed = m_en[0] && !m_sts[0];
        nt    = (m_tmr + 1) % (32'd1 << TB);
        flip  = nt[TB-1] != m_tmr[TB-1];
        m_tmr = nt;
        if (io_wr && m_hit()) begin
            off = int'(io_addr[5:0]);
            case (io_size)
                2'd0: mwb(off, io_wdata);
                2'd1: mww(off, io_wdata & 32'hFFFF);
                2'd2: mwl(off, io_wdata);
                default: ;
            endcase
        end
        if (pwrbtn_evt) m_sts |= 16'h0100;
        if (rtc_evt)    m_sts |= 16'h0400;
        for (int i = 0; i < GH; i++) m_gs[i] |= gpe_evt[8*i +: 8];
        if (flip && armed) m_sts |= 16'h0001;
        m_base = io_base;
    endtask

    function automatic bit m_sci();
        return (m_sts & m_en & 16'h0521) != 0;
    endfunction

    function automatic bit [31:0] m_rdata();
        int off;
        if (!(io_rd && m_hit())) return 0;
        off = int'(io_addr[5:0]);
        case (io_size)
            2'd0: return {24'h0, mrb(off)};
            2'd1: return {16'h0, mrw(off)};
            2'd2: return mrl(off);
            default: return 0;
        endcase
    endfunction

    // ---------------- checking and stimulus ----------------
    task automatic chk(string what, bit [31:0] act, bit [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", cur, what, act, exp, $time);
        end
    endtask

    task automatic step();
        #2;
        chk("sci", {31'b0, sci}, {31'b0, m_sci()});
        chk("rdata", io_rdata, m_rdata());
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic idle(int n);
        repeat (n) step();
    endtask

    task automatic wr(bit [1:0] sz, bit [5:0] off, bit [31:0] d);
        io_addr = cur_base | 16'(off); io_size = sz; io_wdata = d; io_wr = 1'b1;
        step();
        io_wr = 1'b0;
    endtask

    task automatic rd(bit [1:0] sz, bit [5:0] off);
        io_addr = cur_base | 16'(off); io_size = sz; io_rd = 1'b1;
        step();
        io_rd = 1'b0;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_errors++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        @(posedge clk);
        model_update();
        @(negedge clk);
        cur = "R10"; idle(2);
        rst = 1'b0;
        rd(2'd1, 6'h00);

        // R9: zero base, then a misaligned base
        cur = "R9";
        io_base = 16'h0000;
        pwrbtn_evt = 1'b1; step(); pwrbtn_evt = 1'b0;
        io_addr = 16'h0000; io_size = 2'd1; io_rd = 1'b1; step(); io_rd = 1'b0;
        wr(2'd1, 6'h04, 32'h1234);
        io_base = 16'h0410; idle(2);
        io_addr = 16'h0410; io_size = 2'd1; io_rd = 1'b1; step();
        io_addr = 16'h0400; step(); io_rd = 1'b0;
        io_base = cur_base; idle(1);
        rd(2'd1, 6'h04);

        // R5: register map
        cur = "R5";
        rd(2'd1, 6'h00);
        wr(2'd1, 6'h04, 32'h0000BEEF); rd(2'd1, 6'h04);
        wr(2'd2, 6'h30, 32'hA5A50F0F); rd(2'd2, 6'h30);
        rd(2'd1, 6'h06); rd(2'd0, 6'h01); rd(2'd0, 6'h30); rd(2'd3, 6'h00);

        // R11 / R1 / R2: enable pairs
        cur = "R11";
        wr(2'd1, 6'h02, 32'h0100); idle(1);
        cur = "R1";
        wr(2'd1, 6'h02, 32'hFFFF & ~32'h0521); idle(1);
        wr(2'd1, 6'h02, 32'h0400); rtc_evt = 1'b1; step(); rtc_evt = 1'b0; idle(1);
        cur = "R2";
        wr(2'd1, 6'h02, 32'h0000); idle(1);
        wr(2'd1, 6'h02, 32'h0500); rd(2'd1, 6'h00);

        // R3: write-one-to-clear, set beats clear
        cur = "R3";
        wr(2'd1, 6'h00, 32'h0000); rd(2'd1, 6'h00);
        wr(2'd1, 6'h00, 32'h0400); rd(2'd1, 6'h00);
        pwrbtn_evt = 1'b1; wr(2'd1, 6'h00, 32'h0100); pwrbtn_evt = 1'b0;
        rd(2'd1, 6'h00);
        wr(2'd1, 6'h00, 32'hFFFF); rd(2'd1, 6'h00);

        // R4: timer and arming
        cur = "R4";
        wr(2'd1, 6'h02, 32'h0000);
        for (int i = 0; i < 300; i++) rd(2'd2, 6'h08);
        rd(2'd1, 6'h00);
        wr(2'd1, 6'h02, 32'h0001);
        for (int i = 0; i < 300; i++) rd(2'd2, 6'h08);
        rd(2'd1, 6'h00);
        wr(2'd1, 6'h00, 32'h0001);
        for (int i = 0; i < 140; i++) rd(2'd1, 6'h00);
        wr(2'd1, 6'h02, 32'h0000); wr(2'd1, 6'h00, 32'h0001);

        // R6: general-purpose bytes
        cur = "R6";
        gpe_evt = 64'h8000_0000_0300_00A5; step(); gpe_evt = '0;
        for (int i = 0; i < 16; i++) rd(2'd0, 6'(32 + i));
        wr(2'd0, 6'h20, 32'h0000_0021); rd(2'd0, 6'h20);
        wr(2'd0, 6'h2A, 32'h0000_005C); rd(2'd0, 6'h2A);
        gpe_evt = 64'h0000_0000_0000_0004; wr(2'd0, 6'h20, 32'h04); gpe_evt = '0;
        rd(2'd0, 6'h20);

        // R7: word splits into bytes at the same offset
        cur = "R7";
        wr(2'd1, 6'h28, 32'h0000_3355); rd(2'd0, 6'h28); rd(2'd1, 6'h28);
        gpe_evt = 64'h0000_0000_0000_0700; step(); gpe_evt = '0;
        wr(2'd1, 6'h21, 32'h0000_0201); rd(2'd1, 6'h21);
        rd(2'd1, 6'h0A);

        // R8: dword splits into words at the same offset
        cur = "R8";
        wr(2'd2, 6'h02, 32'h0400_0100); rd(2'd1, 6'h02);
        pwrbtn_evt = 1'b1; rtc_evt = 1'b1; step(); pwrbtn_evt = 1'b0; rtc_evt = 1'b0;
        rd(2'd2, 6'h00);
        wr(2'd2, 6'h00, 32'h0400_0100); rd(2'd2, 6'h00);
        wr(2'd2, 6'h29, 32'h1122_3344); rd(2'd0, 6'h29); rd(2'd2, 6'h29);
        wr(2'd2, 6'h04, 32'hCAFE_0001); rd(2'd2, 6'h04);
        wr(2'd2, 6'h08, 32'hFFFF_FFFF); rd(2'd2, 6'h08);

        // R10: reset mid-run
        cur = "R10";
        wr(2'd1, 6'h02, 32'h0100);
        pwrbtn_evt = 1'b1; step(); pwrbtn_evt = 1'b0;
        rst = 1'b1; idle(2); rst = 1'b0;
        rd(2'd1, 6'h00); idle(1);
        rd(2'd1, 6'h02); rd(2'd1, 6'h04); rd(2'd2, 6'h30); rd(2'd0, 6'h2A); rd(2'd2, 6'h08);

        finish_run();
    end

endmodule